// File: doc/BRIEF.md
# Pseudo-SRAM Read Cycle Controller

This block sits between a synchronous host and an external 16-bit pseudo-static RAM and runs asynchronous read cycles on it. The host hands over one request at a time with a ready/valid handshake. A request carries a start address, a two-bit byte mask, a word count and a mode bit. The controller answers with one `rsp_valid` pulse per word read. On the memory side it drives the address, an active-low chip select, an active-low output enable and separate active-low lower and upper byte enables. Every strobe comes from a flop, so all of them switch on one clock edge.

Each timing limit is a parameter in nanoseconds, set alongside the clock period. Minimum times are rounded up to whole clock cycles and the maximum open time is rounded down. There are two burst modes. The incrementing mode steps the address with chip select held low. The fixed mode keeps the address and reads it again by pulsing output enable and the byte enables. A window counter tracks how long the current cycle has stayed open. When the next fixed-address read would push the cycle past its upper limit, the controller raises chip select, waits out the bus turnaround and reopens at the same address. The host sees only the extra latency. The design refuses to elaborate if the open-time limit is shorter than one full access.

Top module: `psram_rd_ctrl`

## Requirements
- R1: While reset is held, all four memory strobes are high, `rsp_valid` is low and `req_ready` is low. Within four cycles of reset release `req_ready` goes high with the strobes still high.
- R2: A request is taken only in a cycle where `req_ready` is high. `req_ready` stays low for as long as chip select is low, so requests offered during a burst wait.
- R3: The first word of a request is sampled on the edge ACC cycles after the accepting edge, where ACC = ceil(max(cycle, address-access, output-enable) time / clock period) (8 by default). `rsp_valid` is high in the cycle after that edge.
- R4: When `req_fixed` = 0, chip select stays low and the address rises by one (wrapping at the address width) on each sampling edge. Words are spaced ACC cycles apart.
- R5: When `req_fixed` = 1, the address is held. Between words, output enable and the byte enables go high for exactly one cycle. Each later read in the same open cycle takes SUBW = 1 + max(ceil(output-enable time / clock), ceil(cycle time / clock) − 1) cycles (8 by default).
- R6: `req_be` bit 0 selects the lower byte (`rsp_data[7:0]`, `mem_lb_n`) and bit 1 selects the upper byte. A deselected byte keeps its enable high for the whole request and is returned as zero.
- R7: No interval from chip select falling, or from an address change, to chip select rising or the next address change lasts longer than MAXW = floor(open limit / clock) cycles (1000 by default). When the next fixed-address read would not fit, chip select rises on the sampling edge. After the gap the same address is reopened with a full access.
- R8: Chip select stays high for at least GAP = max(1, ceil(max(deselect time, output float time) / clock)) cycles (3 by default) between two cycles.
- R9: Every interval between address changes or chip select edges while chip select is low lasts at least ceil(cycle time / clock) cycles.
- R10: A request yields exactly `req_len` + 1 words. They arrive in address order, and each holds the memory word at its address.
- R11: Chip select, output enable and the selected byte enables fall on the same edge that presents the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | AW | Start word address |
| req_be | input | 2 | Byte mask, bit 0 lower, bit 1 upper |
| req_len | input | CW | Words in the burst minus one |
| req_fixed | input | 1 | 1: repeat reads at one address, 0: incrementing |
| rsp_valid | output | 1 | One pulse per returned word |
| rsp_data | output | 16 | Returned word, deselected bytes zero |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_dq | input | 16 | Memory data bus |

## Verification
The bench uses a memory model that puts a wrong value on a byte until every access time for that byte has elapsed since the relevant strobe or address edge. A word sampled too early therefore shows up as a data mismatch. The tests run short incrementing bursts and an incrementing burst that wraps past the top address, which check address stepping separately from sample timing. Single-byte fixed bursts check the one-cycle enable pulse and the zeroing of the deselected byte. A 256-word full-width fixed burst crosses the open-time limit twice, which shows whether the split happens on exactly the right word and whether the reopened access waits the full access time. Back-to-back single-word requests exercise the chip-select gap and the handshake.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int unsigned PSR_NB = 2;
  localparam int unsigned PSR_DW = 8 * PSR_NB;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_STROBE,
    ST_GAP
  } psr_st_e;

  // round a nanosecond time up to whole clock cycles
  function automatic int ticks_up(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psr_window.sv
// Counts cycles since the current read cycle opened and tells the sequencer
// whether one more fixed-address read still fits under the open limit.
module psr_window #(
  parameter int MAX_T = 1000,
  parameter int SUBW  = 8,
  parameter int WIN_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  output logic fits
);

  logic [WIN_W-1:0] win_q, win_d;
  logic             grow;

  assign grow = active && (win_q < WIN_W'(MAX_T));

  always_comb begin
    win_d = win_q;
    if (restart)   win_d = WIN_W'(1);
    else if (grow) win_d = win_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 win_q <= '0;
    else if (restart || grow)   win_q <= win_d;
  end

  assign fits = ({1'b0, win_q} + (WIN_W+1)'(SUBW)) <= (WIN_W+1)'(MAX_T);

endmodule

// File: rtl/psr_capture.sv
// Samples the data bus on the capture edge and zeroes deselected bytes.
module psr_capture #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [NB-1:0] be,
  input  logic [8*NB-1:0] dq,
  output logic          rsp_valid,
  output logic [8*NB-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= cap;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rsp_data[8*b +: 8] <= '0;
      else if (cap) rsp_data[8*b +: 8] <= be[b] ? dq[8*b +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/psr_seq.sv
// Cycle sequencer: opens, paces, re-strobes, splits and closes read cycles.
module psr_seq
  import psr_pkg::*;
#(
  parameter int AW       = 22,
  parameter int CW       = 8,
  parameter int NB       = 2,
  parameter int ACC_T    = 8,
  parameter int SUB_WAIT = 7,
  parameter int GAP_T    = 3,
  parameter int STEP_W   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [NB-1:0] req_be,
  input  logic [CW-1:0] req_len,
  input  logic          req_fixed,
  output logic          req_ready,
  input  logic          fits,
  output logic          win_restart,
  output logic          cap,
  output logic [NB-1:0] cap_be,
  output logic [AW-1:0] mem_addr,
  output logic          cs_n,
  output logic          oe_n,
  output logic [NB-1:0] be_n
);

  psr_st_e          st_q, st_d;
  logic [STEP_W-1:0] cnt_q, cnt_d, tgt;
  logic [AW-1:0]    addr_q, addr_d;
  logic [NB-1:0]    be_q, be_d, ben_q, ben_d;
  logic [CW:0]      left_q, left_d;
  logic             fix_q, fix_d, sub_q, sub_d, res_q, res_d;
  logic             cs_q, cs_d, oe_q, oe_d;

  assign tgt = sub_q ? STEP_W'(SUB_WAIT) : STEP_W'(ACC_T);

  always_comb begin
    st_d = st_q;   cnt_d = cnt_q;  addr_d = addr_q; be_d = be_q;
    left_d = left_q; fix_d = fix_q; sub_d = sub_q;  res_d = res_q;
    cs_d = cs_q;   oe_d = oe_q;    ben_d = ben_q;
    win_restart = 1'b0;
    cap = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid && run) begin
          addr_d = req_addr;  be_d = req_be;  fix_d = req_fixed;
          left_d = {1'b0, req_len} + 1'b1;
          sub_d = 1'b0;  res_d = 1'b0;
          cs_d = 1'b0;  oe_d = 1'b0;  ben_d = ~req_be;
          cnt_d = STEP_W'(1);
          win_restart = 1'b1;
          st_d = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (cnt_q == tgt) begin
          cap = 1'b1;
          left_d = left_q - 1'b1;
          cnt_d = STEP_W'(1);
          if (left_q == (CW+1)'(1)) begin
            cs_d = 1'b1;  oe_d = 1'b1;  ben_d = '1;
            res_d = 1'b0;
            st_d = ST_GAP;
          end else if (!fix_q) begin
            addr_d = addr_q + 1'b1;
            sub_d = 1'b0;
            win_restart = 1'b1;
          end else if (fits) begin
            oe_d = 1'b1;  ben_d = '1;
            st_d = ST_STROBE;
          end else begin
            cs_d = 1'b1;  oe_d = 1'b1;  ben_d = '1;
            res_d = 1'b1;
            st_d = ST_GAP;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STROBE: begin
        oe_d = 1'b0;  ben_d = ~be_q;
        sub_d = 1'b1;
        cnt_d = STEP_W'(1);
        st_d = ST_OPEN;
      end
      ST_GAP: begin
        if (cnt_q == STEP_W'(GAP_T)) begin
          if (res_q) begin
            cs_d = 1'b0;  oe_d = 1'b0;  ben_d = ~be_q;
            sub_d = 1'b0;  res_d = 1'b0;
            cnt_d = STEP_W'(1);
            win_restart = 1'b1;
            st_d = ST_OPEN;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cnt_q <= '0;  addr_q <= '0;  be_q <= '0;
      left_q <= '0;  fix_q <= 1'b0;  sub_q <= 1'b0;  res_q <= 1'b0;
      cs_q <= 1'b1;  oe_q <= 1'b1;  ben_q <= '1;
    end else begin
      st_q <= st_d;  cnt_q <= cnt_d;  addr_q <= addr_d;  be_q <= be_d;
      left_q <= left_d;  fix_q <= fix_d;  sub_q <= sub_d;  res_q <= res_d;
      cs_q <= cs_d;  oe_q <= oe_d;  ben_q <= ben_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE) && run;
  assign cap_be    = be_q;
  assign mem_addr  = addr_q;
  assign cs_n      = cs_q;
  assign oe_n      = oe_q;
  assign be_n      = ben_q;

endmodule

// File: rtl/psram_rd_ctrl.sv
module psram_rd_ctrl
  import psr_pkg::*;
#(
  parameter int AW          = 22,
  parameter int CW          = 8,
  parameter int CLK_NS      = 10,
  parameter int RC_NS       = 80,
  parameter int AA_NS       = 80,
  parameter int OE_NS       = 35,
  parameter int CSH_NS      = 10,
  parameter int HZ_NS       = 25,
  parameter int OPEN_MAX_NS = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [PSR_NB-1:0] req_be,
  input  logic [CW-1:0]     req_len,
  input  logic              req_fixed,
  output logic              rsp_valid,
  output logic [PSR_DW-1:0] rsp_data,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  input  logic [PSR_DW-1:0] mem_dq
);

  localparam int RC_T     = ticks_up(RC_NS, CLK_NS);
  localparam int OE_T     = ticks_up(OE_NS, CLK_NS);
  localparam int ACC_T    = imax(RC_T, imax(ticks_up(AA_NS, CLK_NS), OE_T));
  localparam int SUB_WAIT = imax(OE_T, RC_T - 1);
  localparam int SUBW     = SUB_WAIT + 1;
  localparam int GAP_T    = imax(1, imax(ticks_up(CSH_NS, CLK_NS), ticks_up(HZ_NS, CLK_NS)));
  localparam int MAX_T    = OPEN_MAX_NS / CLK_NS;
  localparam int STEP_W   = $clog2(imax(ACC_T, imax(SUBW, GAP_T)) + 1);
  localparam int WIN_W    = $clog2(MAX_T + SUBW + 1);

  if (MAX_T < ACC_T) begin : g_bad_limit
    $error("open-time limit is shorter than one full access");
  end

  // asynchronous assert, synchronous release
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic              fits, win_restart, cap;
  logic [PSR_NB-1:0] cap_be, be_n;

  psr_seq #(
    .AW(AW), .CW(CW), .NB(PSR_NB), .ACC_T(ACC_T), .SUB_WAIT(SUB_WAIT),
    .GAP_T(GAP_T), .STEP_W(STEP_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_s), .run(rst_s),
    .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be),
    .req_len(req_len), .req_fixed(req_fixed), .req_ready(req_ready),
    .fits(fits), .win_restart(win_restart), .cap(cap), .cap_be(cap_be),
    .mem_addr(mem_addr), .cs_n(mem_cs_n), .oe_n(mem_oe_n), .be_n(be_n)
  );

  psr_window #(.MAX_T(MAX_T), .SUBW(SUBW), .WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_s), .restart(win_restart), .active(!mem_cs_n),
    .fits(fits)
  );

  psr_capture #(.NB(PSR_NB)) u_cap (
    .clk(clk), .rst_n(rst_s), .cap(cap), .be(cap_be), .dq(mem_dq),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign mem_lb_n = be_n[0];
  assign mem_ub_n = be_n[1];

endmodule

// File: rtl/psr_chk.sv
module psr_chk #(
  parameter int AW    = 22,
  parameter int MAX_T = 1000,
  parameter int GAP_T = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_lb_n,
  input logic          mem_ub_n
);

  localparam int OW = $clog2(MAX_T + 2) + 1;
  localparam int HW = $clog2(GAP_T + 1) + 1;

  logic [OW-1:0] open_q, open_now;
  logic [HW-1:0] hi_q;
  logic          cs_d;
  logic [AW-1:0] addr_d;

  assign open_now = (cs_d || (mem_addr != addr_d)) ? OW'(1) : open_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      hi_q   <= HW'(GAP_T);
      cs_d   <= 1'b1;
      addr_d <= '0;
    end else begin
      open_q <= mem_cs_n ? '0 : open_now;
      if (!mem_cs_n)              hi_q <= '0;
      else if (hi_q < HW'(GAP_T)) hi_q <= hi_q + 1'b1;
      cs_d   <= mem_cs_n;
      addr_d <= mem_addr;
    end
  end

  assert_ready_bus_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n));

  assert_capture_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!$past(mem_cs_n) && !$past(mem_oe_n)));

  assert_strobe_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $rose(mem_oe_n)) |=> !mem_oe_n);

  assert_open_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (open_now <= OW'(MAX_T)));

  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (hi_q >= HW'(GAP_T)));

  assert_open_together_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (!mem_oe_n && !(mem_lb_n && mem_ub_n)));

endmodule

bind psram_rd_ctrl psr_chk #(.AW(AW), .MAX_T(MAX_T), .GAP_T(GAP_T)) u_chk (
  .clk(clk), .rst_n(rst_s), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
);

// File: tb/sim_psram_rd_ctrl.sv
module sim_psram_rd_ctrl;

  localparam int CLK_NS = 10;
  localparam int AW = 22;
  localparam int T_RC  = (80 + CLK_NS - 1) / CLK_NS;
  localparam int T_AA  = (80 + CLK_NS - 1) / CLK_NS;
  localparam int T_OE  = (35 + CLK_NS - 1) / CLK_NS;
  localparam int T_CSH = (10 + CLK_NS - 1) / CLK_NS;
  localparam int T_HZ  = (25 + CLK_NS - 1) / CLK_NS;
  localparam int T_ACC = (T_RC > T_AA) ? ((T_RC > T_OE) ? T_RC : T_OE) : ((T_AA > T_OE) ? T_AA : T_OE);
  localparam int T_SUBW = ((T_OE > T_RC - 1) ? T_OE : T_RC - 1) + 1;
  localparam int T_GAP = (T_CSH > T_HZ) ? T_CSH : T_HZ;
  localparam int T_MAX = 10000 / CLK_NS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, req_valid, req_fixed;
  logic          req_ready, rsp_valid;
  logic [AW-1:0] req_addr, mem_addr;
  logic [1:0]    req_be;
  logic [7:0]    req_len;
  logic [15:0]   rsp_data, dq_r;
  logic          mem_cs_n, mem_oe_n, mem_lb_n, mem_ub_n;

  psram_rd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_be(req_be), .req_len(req_len), .req_fixed(req_fixed),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
    .mem_ub_n(mem_ub_n), .mem_dq(dq_r)
  );

  int n_chk = 0, n_bad = 0, edge_no = 0;
  bit mon = 1'b0, done = 1'b0;
  logic [15:0] exp_data[$];
  int          exp_edge[$];
  string       exp_tag[$];

  always @(posedge clk) edge_no <= edge_no + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", req, edge_no, act, expv);
    end
  endtask

  function automatic logic [15:0] mdat(input logic [AW-1:0] a);
    return {a[15:8] ^ a[21:14] ^ 8'hC3, a[7:0] ^ 8'h5A};
  endfunction

  // behavioural expectation of word values and arrival edges
  task automatic push_req(input logic [AW-1:0] a, input logic [1:0] be,
                          input int len, input bit fixed, input int acc);
    int t, w;
    logic [AW-1:0] ai;
    logic [15:0] d;
    string tag;
    t = acc; w = 0;
    for (int i = 0; i <= len; i++) begin
      if (i == 0) begin t += T_ACC; w = T_ACC; tag = "R3"; end
      else if (!fixed) begin t += T_ACC; tag = "R4"; end
      else if (w + T_SUBW <= T_MAX) begin t += T_SUBW; w += T_SUBW; tag = "R5"; end
      else begin t += T_GAP + T_ACC; w = T_ACC; tag = "R7"; end
      ai = fixed ? a : a + AW'(i);
      d = mdat(ai);
      if (!be[0]) d[7:0] = 8'h00;
      if (!be[1]) d[15:8] = 8'h00;
      exp_data.push_back(d);
      exp_edge.push_back(t);
      exp_tag.push_back(tag);
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [1:0] be,
                      input int len, input bit fixed);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_be = be; req_len = 8'(len); req_fixed = fixed;
    while (!req_ready) @(negedge clk);
    push_req(a, be, len, fixed, edge_no + 1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // memory timing model and protocol monitor
  logic          cs_p = 1'b1, oe_p = 1'b1, lb_p = 1'b1, ub_p = 1'b1;
  logic [AW-1:0] ad_p = '0;
  int t_open = 0, t_oe = 0, t_lb = 0, t_ub = 0, t_rise = -1000, t_oeh = 0;

  always @(negedge clk) begin
    if (mon) begin
      int n, dur;
      logic [15:0] want;
      bit lo_ok, hi_ok;
      if (!cs_p && (mem_cs_n || mem_addr != ad_p)) begin
        dur = edge_no - t_open;
        check(dur <= T_MAX, "R7", dur, T_MAX);
        check(dur >= T_RC, "R9", dur, T_RC);
      end
      if (!cs_p && mem_cs_n) t_rise = edge_no;
      if (cs_p && !mem_cs_n) begin
        check(edge_no - t_rise >= T_GAP, "R8", edge_no - t_rise, T_GAP);
        check(!mem_oe_n, "R11", mem_oe_n, 0);
      end
      if (!mem_cs_n && (cs_p || mem_addr != ad_p)) t_open = edge_no;
      if (!mem_cs_n && !cs_p && !oe_p && mem_oe_n) t_oeh = edge_no;
      if (!mem_cs_n && !cs_p && oe_p && !mem_oe_n)
        check(edge_no - t_oeh == 1, "R5", edge_no - t_oeh, 1);
      if (oe_p && !mem_oe_n) t_oe = edge_no;
      if (lb_p && !mem_lb_n) t_lb = edge_no;
      if (ub_p && !mem_ub_n) t_ub = edge_no;
      if (!mem_cs_n) begin
        check(edge_no - t_open <= T_MAX, "R7", edge_no - t_open, T_MAX);
        check(!req_ready, "R2", req_ready, 0);
      end
      if (rsp_valid) begin
        if (exp_data.size() == 0) check(1'b0, "R10", rsp_data, 0);
        else begin
          want = exp_data.pop_front();
          check(rsp_data == want, "R6 R10", rsp_data, want);
          check(edge_no == exp_edge[0], exp_tag[0], edge_no, exp_edge[0]);
          void'(exp_edge.pop_front());
          void'(exp_tag.pop_front());
        end
      end
      n = edge_no + 1;
      lo_ok = !mem_cs_n && !mem_oe_n && !mem_lb_n && (n - t_open >= T_AA) &&
              (n - t_oe >= T_OE) && (n - t_lb >= T_OE);
      hi_ok = !mem_cs_n && !mem_oe_n && !mem_ub_n && (n - t_open >= T_AA) &&
              (n - t_oe >= T_OE) && (n - t_ub >= T_OE);
      dq_r[7:0]  = lo_ok ? mdat(mem_addr) >> 0 : 8'hEE;
      dq_r[15:8] = hi_ok ? mdat(mem_addr) >> 8 : 8'hEE;
      cs_p = mem_cs_n; oe_p = mem_oe_n; lb_p = mem_lb_n; ub_p = mem_ub_n; ad_p = mem_addr;
    end
  end

  always @(posedge clk) begin
    if (!done && edge_no > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog: actual %0d expected %0d words outstanding", exp_data.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_be = 2'b11;
    req_len = '0; req_fixed = 1'b0; dq_r = 16'hEEEE;
    repeat (3) @(negedge clk);
    // R1 held in reset
    check(mem_cs_n && mem_oe_n && mem_lb_n && mem_ub_n, "R1",
          {mem_cs_n, mem_oe_n, mem_lb_n, mem_ub_n}, 4'hF);
    check(!rsp_valid && !req_ready, "R1", {rsp_valid, req_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready, "R1", req_ready, 1);
    check(mem_cs_n && mem_oe_n, "R1", {mem_cs_n, mem_oe_n}, 3);
    mon = 1'b1;

    send(22'h000100, 2'b11, 3, 1'b0);    // R4 incrementing
    send(22'h012345, 2'b01, 4, 1'b1);    // R5 R6 fixed, lower byte only
    send(22'h3FFFFE, 2'b10, 3, 1'b0);    // R4 wrap, R6 upper only
    send(22'h0ABCDE, 2'b11, 255, 1'b1);  // R7 splits twice
    send(22'h000777, 2'b10, 0, 1'b1);    // R8 back to back
    send(22'h001234, 2'b11, 0, 1'b0);
    send(22'h002468, 2'b01, 1, 1'b1);

    while (exp_data.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    check(exp_data.size() == 0, "R10", exp_data.size(), 0);
    check(req_ready && mem_cs_n, "R2", {req_ready, mem_cs_n}, 3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule